// File: doc/BRIEF.md
# Video Processor Host Port Access Controller

This block sits between a host processor and the memory side of a video display processor. The processor sees two byte-wide ports: a control port and a data port. Two control-port writes in sequence set a 14-bit address pointer and pick the target of later data traffic. The target is either video RAM or the 32-entry colour RAM.

Data-port traffic never reaches memory at once. Each access goes into a single-entry queue. It completes only when the display engine offers a memory slot whose column is at least a programmable minimum. A one-byte read-ahead buffer carries the data both ways, and the pointer advances after every completed access.

When a write targets colour RAM, the low six bits of the byte are expanded into a 24-bit RGB value. The block also reports the screen position where the write would show as a one-pixel glitch dot. That position is the current output column, less the output lag, wrapped onto the previous line when needed.

Top module: `vdp_cpu_port`

## Requirements
- R1: Control writes alternate between two phases. The first byte is held as the pointer's low 8 bits. The second byte completes the command: bits [5:0] give pointer bits [13:8] and bits [7:6] give a code. Code 00 sets the pointer, selects video RAM and queues a read. Code 01 sets the pointer and selects video RAM. Code 11 sets the pointer and selects colour RAM. Code 10 leaves the pointer, the target and the queue untouched.
- R2: At most one access is queued. A new data-port or read-setup request replaces whatever is pending, so back-to-back writes with no slot in between perform one memory write carrying the last byte.
- R3: A queued access completes only in a cycle with `slot_valid` high and `slot_column` >= `min_column`. Otherwise it stays pending.
- R4: A completed write with video RAM selected drives `vram_we` with `vram_addr` equal to the pointer and `vram_wdata` equal to the read-ahead buffer.
- R5: A completed read drives `vram_re` at the pointer. The byte returned on `vram_rdata` in the following cycle is loaded into the read-ahead buffer, and `cpu_rdata` shows it one cycle after that.
- R6: Every completed access increments the 14-bit pointer by one, wrapping from 0x3FFF to 0x0000, and empties the queue.
- R7: A completed write with colour RAM selected drives `cram_we` and does not drive `vram_we`. `cram_idx` is pointer bits [4:0]. `cram_rgb` is {red, green, blue}, one byte each, taken from buffer bits [1:0], [3:2] and [5:4]. Red and green map 0..3 to 0, 85, 170, 255; blue maps 0..3 to 0, 104, 170, 255.
- R8: With each colour RAM write, `dot_valid` is high and the dot position is `out_column` - 11 on `out_row`. When `out_column` < 11, 342 is added to the column and the row steps back by one, with row 0 going to row 261.
- R9: A control-port read, a data-port read or a data-port write returns the control sequence to its first phase.
- R10: A data-port write loads the byte into the read-ahead buffer and queues a write. A data-port read returns the buffer on `cpu_rdata` and queues a read.
- R11: After reset the control sequence is in its first phase, the queue is empty, and the buffer, the pointer and the target (video RAM) are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Host write strobe, one cycle |
| cpu_rd | input | 1 | Host read strobe, one cycle |
| cpu_ctrl | input | 1 | 1 selects the control port, 0 selects the data port |
| cpu_wdata | input | 8 | Host write byte |
| cpu_rdata | output | 8 | Read-ahead buffer, returned on data reads |
| slot_valid | input | 1 | Memory slot offered this cycle |
| slot_column | input | 9 | Column of the offered slot |
| min_column | input | 9 | Earliest column at which a queued access may complete |
| out_row | input | 9 | Current output row |
| out_column | input | 9 | Current output column |
| vram_we | output | 1 | Video RAM write strobe |
| vram_re | output | 1 | Video RAM read strobe |
| vram_addr | output | 14 | Video RAM address (pointer) |
| vram_wdata | output | 8 | Video RAM write byte |
| vram_rdata | input | 8 | Video RAM read byte, one cycle after `vram_re` |
| cram_we | output | 1 | Colour RAM write strobe |
| cram_idx | output | 5 | Colour RAM entry |
| cram_rgb | output | 24 | Expanded colour {R,G,B} |
| dot_valid | output | 1 | Glitch dot report |
| dot_row | output | 9 | Glitch dot row |
| dot_column | output | 9 | Glitch dot column |

## Verification
Several access patterns are run, and each one isolates a different fault:

- Sequential video RAM writes from a mid-range address and across the 0x3FFF boundary expose errors in pointer stepping and masking.
- Holding the slot column below, then equal to, the minimum separates a wrong comparison from a missing gate.
- Two writes with slots withheld reveal whether the queue merges requests or replays them.
- Prefetching reads from a pointer set with code 00 tests the read-ahead latency and the byte order.
- An aborted half command and the ignored code 10 are each followed by an address setup and a data write, which shows that the phase and the pointer behave as required.
- Colour writes at columns above, at and below the lag, including on row 0, cover both scales and both wrap paths of the dot position.

// File: rtl/vdp_port_pkg.sv
package vdp_port_pkg;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   typedef enum logic [1:0] {
      CMD_VRD  = 2'b00,
      CMD_VWR  = 2'b01,
      CMD_REG  = 2'b10,
      CMD_CRAM = 2'b11
   } cmd_code_e;

endpackage

// File: rtl/vdp_cmd_decode.sv
module vdp_cmd_decode
   import vdp_port_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic              cpu_ctrl,
   input  logic [7:0]        cpu_wdata,
   output logic              ptr_load,
   output logic [ADDR_W-1:0] ptr_value,
   output logic              tgt_load,
   output logic              tgt_cram,
   output logic              req_valid,
   output acc_kind_e         req_kind,
   output logic              buf_load,
   output logic [7:0]        buf_value
);
   localparam int HI_W = ADDR_W - 8;

   logic       second_q;
   logic [7:0] low_q;
   logic       ctrl_wr, data_wr, data_rd, complete;
   cmd_code_e  code;

   always_comb begin
      ctrl_wr   = cpu_wr & cpu_ctrl;
      data_wr   = cpu_wr & ~cpu_ctrl;
      data_rd   = cpu_rd & ~cpu_ctrl;
      complete  = ctrl_wr & second_q;
      code      = cmd_code_e'(cpu_wdata[7:6]);
      ptr_load  = complete && (code != CMD_REG);
      ptr_value = {cpu_wdata[HI_W-1:0], low_q};
      tgt_load  = ptr_load;
      tgt_cram  = (code == CMD_CRAM);
      req_valid = (complete && (code == CMD_VRD)) || data_wr || data_rd;
      req_kind  = data_wr ? ACC_WRITE : ACC_READ;
      buf_load  = data_wr;
      buf_value = cpu_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         second_q <= 1'b0;
         low_q    <= '0;
      end else if (ctrl_wr) begin
         if (!second_q) begin
            low_q    <= cpu_wdata;
            second_q <= 1'b1;
         end else begin
            second_q <= 1'b0;
         end
      end else if (cpu_rd || data_wr) begin
         second_q <= 1'b0;
      end
   end

endmodule

// File: rtl/vdp_access_unit.sv
module vdp_access_unit
   import vdp_port_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int COL_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_load,
   input  logic [ADDR_W-1:0] ptr_value,
   input  logic              tgt_load,
   input  logic              tgt_cram,
   input  logic              req_valid,
   input  acc_kind_e         req_kind,
   input  logic              buf_load,
   input  logic [7:0]        buf_value,
   input  logic              slot_valid,
   input  logic [COL_W-1:0]  slot_column,
   input  logic [COL_W-1:0]  min_column,
   input  logic [7:0]        vram_rdata,
   output logic              do_vram_write,
   output logic              do_cram_write,
   output logic              do_read,
   output logic [ADDR_W-1:0] ptr,
   output logic [7:0]        rab
);
   acc_kind_e queue_q;
   logic      cram_sel_q;
   logic      rd_pend_q;
   logic      fire;

   always_comb begin
      fire          = slot_valid && (slot_column >= min_column) && (queue_q != ACC_NONE);
      do_read       = fire && (queue_q == ACC_READ);
      do_vram_write = fire && (queue_q == ACC_WRITE) && !cram_sel_q;
      do_cram_write = fire && (queue_q == ACC_WRITE) && cram_sel_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         queue_q    <= ACC_NONE;
         ptr        <= '0;
         cram_sel_q <= 1'b0;
         rd_pend_q  <= 1'b0;
         rab        <= '0;
      end else begin
         if (req_valid)
            queue_q <= req_kind;
         else if (fire)
            queue_q <= ACC_NONE;

         if (ptr_load)
            ptr <= ptr_value;
         else if (fire)
            ptr <= ptr + ADDR_W'(1);

         if (tgt_load)
            cram_sel_q <= tgt_cram;

         rd_pend_q <= do_read;

         if (buf_load)
            rab <= buf_value;
         else if (rd_pend_q)
            rab <= vram_rdata;
      end
   end

endmodule

// File: rtl/vdp_colour_expand.sv
module vdp_colour_expand #(
   parameter bit NONLINEAR_BLUE = 1'b1
) (
   input  logic [5:0]  code,
   output logic [23:0] rgb
);
   function automatic logic [7:0] lin_level(input logic [1:0] v);
      return {v, v, v, v};
   endfunction

   logic [7:0] blue;

   generate
      if (NONLINEAR_BLUE) begin : g_blue_curve
         always_comb begin
            case (code[5:4])
               2'd0:    blue = 8'd0;
               2'd1:    blue = 8'd104;
               2'd2:    blue = 8'd170;
               default: blue = 8'd255;
            endcase
         end
      end else begin : g_blue_linear
         always_comb blue = lin_level(code[5:4]);
      end
   endgenerate

   always_comb rgb = {lin_level(code[1:0]), lin_level(code[3:2]), blue};

endmodule

// File: rtl/vdp_dot_locate.sv
module vdp_dot_locate #(
   parameter int COL_W       = 9,
   parameter int ROW_W       = 9,
   parameter int LINE_CYCLES = 342,
   parameter int FRAME_LINES = 262,
   parameter int OUTPUT_LAG  = 11
) (
   input  logic [ROW_W-1:0] row_in,
   input  logic [COL_W-1:0] col_in,
   output logic [ROW_W-1:0] row_out,
   output logic [COL_W-1:0] col_out
);
   localparam logic [COL_W-1:0] LAG      = COL_W'(OUTPUT_LAG);
   localparam logic [COL_W-1:0] WRAP_ADD = COL_W'(LINE_CYCLES - OUTPUT_LAG);
   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(FRAME_LINES - 1);

   always_comb begin
      if (col_in >= LAG) begin
         col_out = col_in - LAG;
         row_out = row_in;
      end else begin
         col_out = col_in + WRAP_ADD;
         row_out = (row_in == '0) ? LAST_ROW : row_in - ROW_W'(1);
      end
   end

endmodule

// File: rtl/vdp_cpu_port.sv
module vdp_cpu_port
   import vdp_port_pkg::*;
#(
   parameter int ADDR_W         = 14,
   parameter int CRAM_IDX_W     = 5,
   parameter int COL_W          = 9,
   parameter int ROW_W          = 9,
   parameter int LINE_CYCLES    = 342,
   parameter int FRAME_LINES    = 262,
   parameter int OUTPUT_LAG     = 11,
   parameter bit NONLINEAR_BLUE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cpu_wr,
   input  logic                  cpu_rd,
   input  logic                  cpu_ctrl,
   input  logic [7:0]            cpu_wdata,
   output logic [7:0]            cpu_rdata,
   input  logic                  slot_valid,
   input  logic [COL_W-1:0]      slot_column,
   input  logic [COL_W-1:0]      min_column,
   input  logic [ROW_W-1:0]      out_row,
   input  logic [COL_W-1:0]      out_column,
   output logic                  vram_we,
   output logic                  vram_re,
   output logic [ADDR_W-1:0]     vram_addr,
   output logic [7:0]            vram_wdata,
   input  logic [7:0]            vram_rdata,
   output logic                  cram_we,
   output logic [CRAM_IDX_W-1:0] cram_idx,
   output logic [23:0]           cram_rgb,
   output logic                  dot_valid,
   output logic [ROW_W-1:0]      dot_row,
   output logic [COL_W-1:0]      dot_column
);
   generate
      if (ADDR_W < 9 || ADDR_W > 14) begin : g_bad_addr
         $error("ADDR_W must lie in 9..14");
      end
      if (CRAM_IDX_W < 1 || CRAM_IDX_W > ADDR_W) begin : g_bad_idx
         $error("CRAM_IDX_W must lie in 1..ADDR_W");
      end
      if (LINE_CYCLES > (1 << COL_W) || OUTPUT_LAG >= LINE_CYCLES) begin : g_bad_line
         $error("line length or lag does not fit COL_W");
      end
      if (FRAME_LINES > (1 << ROW_W) || FRAME_LINES < 2) begin : g_bad_frame
         $error("FRAME_LINES does not fit ROW_W");
      end
   endgenerate

   logic              ptr_load, tgt_load, tgt_cram, req_valid, buf_load;
   logic [ADDR_W-1:0] ptr_value, ptr;
   acc_kind_e         req_kind;
   logic [7:0]        buf_value, rab;
   logic              do_vram_write, do_cram_write, do_read;

   vdp_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_wr    (cpu_wr),
      .cpu_rd    (cpu_rd),
      .cpu_ctrl  (cpu_ctrl),
      .cpu_wdata (cpu_wdata),
      .ptr_load  (ptr_load),
      .ptr_value (ptr_value),
      .tgt_load  (tgt_load),
      .tgt_cram  (tgt_cram),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .buf_load  (buf_load),
      .buf_value (buf_value)
   );

   vdp_access_unit #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_access (
      .clk           (clk),
      .rst_n         (rst_n),
      .ptr_load      (ptr_load),
      .ptr_value     (ptr_value),
      .tgt_load      (tgt_load),
      .tgt_cram      (tgt_cram),
      .req_valid     (req_valid),
      .req_kind      (req_kind),
      .buf_load      (buf_load),
      .buf_value     (buf_value),
      .slot_valid    (slot_valid),
      .slot_column   (slot_column),
      .min_column    (min_column),
      .vram_rdata    (vram_rdata),
      .do_vram_write (do_vram_write),
      .do_cram_write (do_cram_write),
      .do_read       (do_read),
      .ptr           (ptr),
      .rab           (rab)
   );

   vdp_colour_expand #(.NONLINEAR_BLUE(NONLINEAR_BLUE)) u_colour (
      .code (rab[5:0]),
      .rgb  (cram_rgb)
   );

   vdp_dot_locate #(
      .COL_W       (COL_W),
      .ROW_W       (ROW_W),
      .LINE_CYCLES (LINE_CYCLES),
      .FRAME_LINES (FRAME_LINES),
      .OUTPUT_LAG  (OUTPUT_LAG)
   ) u_dot (
      .row_in  (out_row),
      .col_in  (out_column),
      .row_out (dot_row),
      .col_out (dot_column)
   );

   always_comb begin
      cpu_rdata  = rab;
      vram_we    = do_vram_write;
      vram_re    = do_read;
      vram_addr  = ptr;
      vram_wdata = rab;
      cram_we    = do_cram_write;
      cram_idx   = ptr[CRAM_IDX_W-1:0];
      dot_valid  = do_cram_write;
   end

endmodule

// File: rtl/vdp_cpu_port_chk.sv
module vdp_cpu_port_chk #(
   parameter int ADDR_W = 14,
   parameter int COL_W  = 9,
   parameter int LINE_CYCLES = 342
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_wr,
   input logic              cpu_rd,
   input logic              cpu_ctrl,
   input logic              slot_valid,
   input logic [COL_W-1:0]  slot_column,
   input logic [COL_W-1:0]  min_column,
   input logic              vram_we,
   input logic              vram_re,
   input logic [ADDR_W-1:0] vram_addr,
   input logic              cram_we,
   input logic [23:0]       cram_rgb,
   input logic              dot_valid,
   input logic [COL_W-1:0]  dot_column
);
   logic any_acc;
   always_comb any_acc = vram_we || vram_re || cram_we;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({vram_we, vram_re, cram_we}) <= 1); // R7

   AST_SLOT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      any_acc |-> (slot_valid && slot_column >= min_column)); // R3

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (any_acc && !(cpu_wr && cpu_ctrl)) |=> (vram_addr == $past(vram_addr) + ADDR_W'(1))); // R6

   AST_QUEUE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (any_acc && !cpu_wr && !cpu_rd) |=> !any_acc); // R2

   AST_RED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      cram_we |-> (cram_rgb[23:16] inside {8'd0, 8'd85, 8'd170, 8'd255})); // R7

   AST_DOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      dot_valid |-> (int'(dot_column) < LINE_CYCLES)); // R8

endmodule

bind vdp_cpu_port vdp_cpu_port_chk #(
   .ADDR_W      (ADDR_W),
   .COL_W       (COL_W),
   .LINE_CYCLES (LINE_CYCLES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_wr      (cpu_wr),
   .cpu_rd      (cpu_rd),
   .cpu_ctrl    (cpu_ctrl),
   .slot_valid  (slot_valid),
   .slot_column (slot_column),
   .min_column  (min_column),
   .vram_we     (vram_we),
   .vram_re     (vram_re),
   .vram_addr   (vram_addr),
   .cram_we     (cram_we),
   .cram_rgb    (cram_rgb),
   .dot_valid   (dot_valid),
   .dot_column  (dot_column)
);

// File: tb/test_vdp_cpu_port.sv
`timescale 1ns/1ps
module test_vdp_cpu_port;

   typedef struct {
      bit          is_cram;
      logic [13:0] addr;
      logic [7:0]  data;
      logic [23:0] rgb;
      logic [8:0]  drow;
      logic [8:0]  dcol;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_ctrl = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic        slot_valid = 1'b1;
   logic [8:0]  slot_column = 9'd200, min_column = 9'd0;
   logic [8:0]  out_row = 9'd50, out_column = 9'd100;
   logic        vram_we, vram_re, cram_we, dot_valid;
   logic [13:0] vram_addr;
   logic [7:0]  vram_wdata;
   logic [7:0]  vram_rdata = '0;
   logic [4:0]  cram_idx;
   logic [23:0] cram_rgb;
   logic [8:0]  dot_row, dot_column;

   int   n_chk = 0, n_fail = 0;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   vdp_cpu_port i_vdp_cpu_port (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_ctrl(cpu_ctrl),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .slot_valid(slot_valid),
      .slot_column(slot_column), .min_column(min_column), .out_row(out_row),
      .out_column(out_column), .vram_we(vram_we), .vram_re(vram_re),
      .vram_addr(vram_addr), .vram_wdata(vram_wdata), .vram_rdata(vram_rdata),
      .cram_we(cram_we), .cram_idx(cram_idx), .cram_rgb(cram_rgb),
      .dot_valid(dot_valid), .dot_row(dot_row), .dot_column(dot_column)
   );

   function automatic logic [7:0] mem_byte(input logic [13:0] a);
      return a[7:0] ^ {2'b00, a[13:8]} ^ 8'hA5;
   endfunction

   always @(posedge clk) if (vram_re) vram_rdata <= mem_byte(vram_addr);

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic bus(input bit ctrl, input bit wr, input bit rd, input logic [7:0] d);
      cpu_ctrl = ctrl; cpu_wr = wr; cpu_rd = rd; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_ctrl = 1'b0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_addr(input logic [13:0] a, input logic [1:0] code);
      bus(1'b1, 1'b1, 1'b0, a[7:0]);
      bus(1'b1, 1'b1, 1'b0, {code, a[13:8]});
   endtask

   function automatic logic [7:0] rg_lvl(input logic [1:0] v);
      case (v) 2'd0: return 8'd0; 2'd1: return 8'd85; 2'd2: return 8'd170; default: return 8'd255; endcase
   endfunction
   function automatic logic [7:0] b_lvl(input logic [1:0] v);
      case (v) 2'd0: return 8'd0; 2'd1: return 8'd104; 2'd2: return 8'd170; default: return 8'd255; endcase
   endfunction

   task automatic push_vram(input logic [13:0] a, input logic [7:0] d, input string tag);
      exp_t e;
      e.is_cram = 1'b0; e.addr = a; e.data = d; e.rgb = '0; e.drow = '0; e.dcol = '0; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic push_cram(input logic [4:0] idx, input logic [7:0] d, input string tag);
      exp_t e;
      int c, r;
      c = int'(out_column) - 11;
      r = int'(out_row);
      if (c < 0) begin
         c += 342;
         r = (r == 0) ? 261 : r - 1;
      end
      e.is_cram = 1'b1; e.addr = {9'd0, idx}; e.data = d;
      e.rgb = {rg_lvl(d[1:0]), rg_lvl(d[3:2]), b_lvl(d[5:4])};
      e.drow = 9'(r); e.dcol = 9'(c); e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic wr_data(input logic [7:0] d);
      bus(1'b0, 1'b1, 1'b0, d);
   endtask

   task automatic rd_data(input logic [7:0] exp, input string tag);
      cpu_ctrl = 1'b0; cpu_rd = 1'b1;
      #0.5;
      chk(cpu_rdata == exp, tag, "data read", {24'd0, cpu_rdata}, {24'd0, exp});
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   // Monitor: pops expected memory writes as the design produces them
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && (vram_we || cram_we)) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3", "unexpected write", {8'd0, cram_we, vram_we, vram_addr}, 32'd0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               if (e.is_cram) begin
                  chk(cram_we && !vram_we, e.tag, "colour target", {30'd0, cram_we, vram_we}, 32'd2);
                  chk(cram_idx == e.addr[4:0], e.tag, "colour index", {27'd0, cram_idx}, {27'd0, e.addr[4:0]});
                  chk(cram_rgb == e.rgb, "R7", "rgb", {8'd0, cram_rgb}, {8'd0, e.rgb});
                  chk(dot_valid && dot_row == e.drow && dot_column == e.dcol, "R8", "dot row/col",
                      {14'd0, dot_row, dot_column}, {14'd0, e.drow, e.dcol});
               end else begin
                  chk(vram_we && !cram_we, e.tag, "vram target", {30'd0, cram_we, vram_we}, 32'd1);
                  chk(vram_addr == e.addr, e.tag, "vram addr", {18'd0, vram_addr}, {18'd0, e.addr});
                  chk(vram_wdata == e.data, "R4", "vram data", {24'd0, vram_wdata}, {24'd0, e.data});
               end
            end
         end
      end
   end

   initial begin
      #(4 * 20000);
      chk(1'b0, "WATCHDOG", "timeout", 32'd0, 32'd1);
      report();
   end

   initial begin
      cyc(4);
      // R11: reset state
      chk(cpu_rdata == 8'd0, "R11", "buffer after reset", {24'd0, cpu_rdata}, 32'd0);
      chk(!vram_we && !vram_re && !cram_we, "R11", "idle strobes",
          {29'd0, vram_we, vram_re, cram_we}, 32'd0);
      chk(vram_addr == 14'd0, "R11", "pointer after reset", {18'd0, vram_addr}, 32'd0);
      rst_n = 1'b1;
      cyc(2);

      // R1 R4 R6 R10: two writes from 0x1234
      set_addr(14'h1234, 2'b01);
      push_vram(14'h1234, 8'hAB, "R1"); wr_data(8'hAB); cyc(3);
      push_vram(14'h1235, 8'hCD, "R6"); wr_data(8'hCD); cyc(3);
      chk(cpu_rdata == 8'hCD, "R10", "write loads buffer", {24'd0, cpu_rdata}, 32'hCD);

      // R3: slot column below minimum keeps the write pending
      min_column = 9'd100; slot_column = 9'd50;
      wr_data(8'h5A); cyc(6);
      chk(exp_q.size() == 0, "R3", "no early write", exp_q.size(), 32'd0);
      push_vram(14'h1236, 8'h5A, "R3");
      slot_column = 9'd100; cyc(3);
      chk(exp_q.size() == 0, "R3", "write at equal column", exp_q.size(), 32'd0);
      min_column = 9'd0; slot_column = 9'd200;

      // R2: two writes with no slot collapse into one
      slot_valid = 1'b0;
      wr_data(8'h11); wr_data(8'h22); cyc(2);
      push_vram(14'h1237, 8'h22, "R2");
      slot_valid = 1'b1; cyc(4);
      push_vram(14'h1238, 8'h33, "R2"); wr_data(8'h33); cyc(3);
      chk(exp_q.size() == 0, "R2", "single write drained", exp_q.size(), 32'd0);

      // R5 R10: read setup prefetch, then read-ahead chain
      set_addr(14'h0200, 2'b00); cyc(5);
      rd_data(mem_byte(14'h0200), "R5"); cyc(5);
      rd_data(mem_byte(14'h0201), "R10"); cyc(5);
      rd_data(mem_byte(14'h0202), "R5");

      // R9: control read and data write abort a half command
      bus(1'b1, 1'b1, 1'b0, 8'h77);
      bus(1'b1, 1'b0, 1'b1, 8'h00);
      set_addr(14'h0010, 2'b01);
      push_vram(14'h0010, 8'h44, "R9"); wr_data(8'h44); cyc(3);
      bus(1'b1, 1'b1, 1'b0, 8'h99);
      push_vram(14'h0011, 8'h55, "R9"); wr_data(8'h55); cyc(3);
      set_addr(14'h0020, 2'b01);
      push_vram(14'h0020, 8'h66, "R9"); wr_data(8'h66); cyc(3);

      // R6: pointer wraps at 14 bits
      set_addr(14'h3FFF, 2'b01);
      push_vram(14'h3FFF, 8'h01, "R6"); wr_data(8'h01); cyc(3);
      push_vram(14'h0000, 8'h02, "R6"); wr_data(8'h02); cyc(3);

      // R1: code 10 leaves the pointer alone
      set_addr(14'h0500, 2'b10);
      push_vram(14'h0001, 8'h03, "R1"); wr_data(8'h03); cyc(3);

      // R7 R8: colour RAM writes
      set_addr(14'h0025, 2'b11);
      out_row = 9'd100; out_column = 9'd20;
      push_cram(5'd5, 8'h3F, "R7"); wr_data(8'h3F); cyc(3);
      out_column = 9'd5;
      push_cram(5'd6, 8'h10, "R8"); wr_data(8'h10); cyc(3);
      out_row = 9'd0; out_column = 9'd11;
      push_cram(5'd7, 8'h06, "R8"); wr_data(8'h06); cyc(3);
      out_column = 9'd3;
      push_cram(5'd8, 8'h2B, "R8"); wr_data(8'h2B); cyc(3);

      // R7: reselecting video RAM
      set_addr(14'h0100, 2'b01);
      push_vram(14'h0100, 8'h77, "R7"); wr_data(8'h77); cyc(5);

      chk(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 32'd0);
      report();
   end

endmodule